// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two unsigned 16-bit operands and a carry-in in purely combinational logic. Every bit position first classifies itself as generating a carry (both operand bits set) or passing one along (operand bits differ). Four-bit slices fold those flags into one slice-wide generate and pass flag. A second lookahead stage combines the four slice flags with the carry-in and delivers the carry entering each slice. Each slice then expands its incoming carry into the carries of its own bits, and each sum bit is the pass flag of that bit XOR its incoming carry.

One parameterised four-input lookahead cell is used at both levels. At the lower level it works on bit flags. At the upper level it works on slice flags. Because the block exports the whole-word generate and pass flags, it can itself serve as one operand slice of a wider lookahead tree.

Top module: `cla_adder16`

## Requirements
- R1: `sum_o` equals the low 16 bits of a_i + b_i + cin for every operand pair and both carry-in values.
- R2: `cout` equals bit 16 of a_i + b_i + cin, as an unsigned 17-bit result.
- R3: `grp_g` is 1 exactly when a_i + b_i, with cin ignored, is 2^16 or more. It does not depend on cin.
- R4: `grp_p` is 1 exactly when a_i XOR b_i is all ones (0xFFFF). It does not depend on cin.
- R5: `grp_g` and `grp_p` are never 1 at the same time.
- R6: When every bit only passes the carry on (a_i XOR b_i = 0xFFFF, a_i AND b_i = 0), cin = 1 gives sum_o = 0x0000 and cout = 1, and cin = 0 gives sum_o = 0xFFFF and cout = 0.
- R7: A carry generated at bit 0 (a_i = 0x0001, b_i = 0xFFFF) crosses all three slice boundaries. The result is sum_o = 0x0000 (cin = 0) or 0x0001 (cin = 1), with cout = 1 and grp_g = 1.
- R8: The carry entering each 4-bit slice at bits 4, 8 and 12 equals the carry out of the arithmetic sum of the lower bits. A slice whose operand bits are all zero therefore shows exactly that carry as its sum nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum, modulo 2^16 |
| cout | output | 1 | Carry out of bit 15 |
| grp_g | output | 1 | Whole-word carry generate |
| grp_p | output | 1 | Whole-word carry pass-through |

## Verification
The adder holds no state, so a wrong lookahead term shows up at the outputs as soon as the inputs settle. The failure is confined to operand patterns that use that term. A bad slice-level carry corrupts only the nibble above the faulty boundary and only when the lower bits produce or pass a carry. The sweep therefore drives every combination of kill, generate, pass and mixed patterns across the four slices with both carry-in values, and adds pseudo-random vectors. Flag errors in the upper cell show up in `grp_g`, `grp_p` or `cout` even when the sum is correct.

// File: rtl/cla_pkg.sv
package cla_pkg;
   // fan-in of the lookahead cell used at every level
   localparam int unsigned CELL_ARITY = 4;

   // number of lookahead levels needed to cover a word of the given width
   function automatic int unsigned level_count(input int unsigned width);
      int unsigned span;
      int unsigned lv;
      span = 1;
      lv   = 0;
      while (span < width && lv < 16) begin
         span = span * CELL_ARITY;
         lv   = lv + 1;
      end
      return lv;
   endfunction
endpackage

// File: rtl/cla_pg_bits.sv
module cla_pg_bits #(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] gen_o,
   output logic [WIDTH-1:0] prop_o
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("cla_pg_bits: WIDTH must be at least 1");
      end
   endgenerate

   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_bit
         assign gen_o[i]  = a_i[i] & b_i[i];
         assign prop_o[i] = a_i[i] ^ b_i[i];
      end
   endgenerate

   // a bit can never both generate and pass a carry (R5 foundation)
   always_comb begin
      a_r5_bit_exclusive: assert ((gen_o & prop_o) == '0)
         else $error("bit generate and pass flags overlap");
   end
endmodule

// File: rtl/cla_cell.sv
module cla_cell #(
   parameter int unsigned ARITY = cla_pkg::CELL_ARITY
) (
   input  logic [ARITY-1:0] g_in,
   input  logic [ARITY-1:0] p_in,
   input  logic             c_in,
   output logic [ARITY-1:0] c_out,
   output logic             grp_g,
   output logic             grp_p
);
   generate
      if (ARITY < 2 || ARITY > 8) begin : g_bad_arity
         $error("cla_cell: ARITY must lie between 2 and 8");
      end
   endgenerate

   // flat sum-of-products carry into position 'upto' of this cell
   function automatic logic lookahead(input logic [ARITY-1:0] g,
                                      input logic [ARITY-1:0] p,
                                      input logic             ci,
                                      input int unsigned      upto);
      logic acc;
      logic term;
      acc = 1'b0;
      for (int j = 0; j < ARITY; j++) begin
         if (j < upto) begin
            term = g[j];
            for (int m = 0; m < ARITY; m++) begin
               if (m > j && m < upto) term = term & p[m];
            end
            acc = acc | term;
         end
      end
      term = ci;
      for (int m = 0; m < ARITY; m++) begin
         if (m < upto) term = term & p[m];
      end
      return acc | term;
   endfunction

   genvar k;
   generate
      for (k = 0; k < ARITY; k++) begin : g_carry
         assign c_out[k] = lookahead(g_in, p_in, c_in, k);
      end
   endgenerate

   assign grp_g = lookahead(g_in, p_in, 1'b0, ARITY);
   assign grp_p = &p_in;

   always_comb begin
      // R5: exclusive inputs give exclusive group flags
      if ((g_in & p_in) == '0) begin
         a_r5_cell_exclusive: assert (!(grp_g && grp_p))
            else $error("cell group flags both set");
      end
      // R8: the lowest carry is the incoming carry itself
      a_r8_cell_entry: assert (c_out[0] == c_in)
         else $error("cell entry carry differs from c_in");
      // R6: a fully passing cell forwards its carry to every position
      if (grp_p) begin
         a_r6_cell_pass: assert (c_out == {ARITY{c_in}})
            else $error("passing cell did not forward its carry");
      end
   end
endmodule

// File: rtl/cla_sum_bits.sv
module cla_sum_bits #(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] prop_i,
   input  logic [WIDTH-1:0] carry_i,
   output logic [WIDTH-1:0] sum_o
);
   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_bit
         assign sum_o[i] = prop_i[i] ^ carry_i[i];
      end
   endgenerate
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout,
   output logic             grp_g,
   output logic             grp_p
);
   import cla_pkg::*;

   localparam int unsigned ARITY  = CELL_ARITY;
   localparam int unsigned GROUPS = WIDTH / ARITY;
   localparam int unsigned LEVELS = level_count(WIDTH);

   generate
      if (WIDTH != ARITY * ARITY || LEVELS != 2) begin : g_bad_cfg
         $error("cla_adder16: WIDTH must equal CELL_ARITY squared (two levels)");
      end
   endgenerate

   logic [WIDTH-1:0]  bit_g, bit_p, bit_c;
   logic [GROUPS-1:0] blk_g, blk_p, blk_c;

   cla_pg_bits #(.WIDTH(WIDTH)) u_pg (
      .a_i   (a_i),
      .b_i   (b_i),
      .gen_o (bit_g),
      .prop_o(bit_p)
   );

   genvar gi;
   generate
      for (gi = 0; gi < GROUPS; gi++) begin : g_slice
         cla_cell #(.ARITY(ARITY)) u_lo (
            .g_in (bit_g[gi*ARITY +: ARITY]),
            .p_in (bit_p[gi*ARITY +: ARITY]),
            .c_in (blk_c[gi]),
            .c_out(bit_c[gi*ARITY +: ARITY]),
            .grp_g(blk_g[gi]),
            .grp_p(blk_p[gi])
         );
      end
   endgenerate

   cla_cell #(.ARITY(GROUPS)) u_hi (
      .g_in (blk_g),
      .p_in (blk_p),
      .c_in (cin),
      .c_out(blk_c),
      .grp_g(grp_g),
      .grp_p(grp_p)
   );

   cla_sum_bits #(.WIDTH(WIDTH)) u_sum (
      .prop_i (bit_p),
      .carry_i(bit_c),
      .sum_o  (sum_o)
   );

   assign cout = grp_g | (grp_p & cin);

   // arithmetic reference for the assertions below
   logic [WIDTH:0] chk_full;
   logic [WIDTH:0] chk_nocin;
   assign chk_full  = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin};
   assign chk_nocin = {1'b0, a_i} + {1'b0, b_i};

   always_comb begin
      a_r1_sum: assert (sum_o == chk_full[WIDTH-1:0])
         else $error("sum differs from arithmetic result");
      a_r2_cout: assert (cout == chk_full[WIDTH])
         else $error("carry-out differs from arithmetic result");
      a_r3_grp_gen: assert (grp_g == chk_nocin[WIDTH])
         else $error("word generate flag wrong");
      a_r4_grp_prop: assert (grp_p == ((a_i ^ b_i) == {WIDTH{1'b1}}))
         else $error("word pass flag wrong");
      a_r5_word_exclusive: assert (!(grp_g && grp_p))
         else $error("word flags both set");
   end

   // R8: slice entry carries match the arithmetic carry from lower bits
   genvar bi;
   generate
      for (bi = 1; bi < GROUPS; bi++) begin : g_entry_chk
         logic [bi*ARITY:0] low_sum;
         assign low_sum = {1'b0, a_i[bi*ARITY-1:0]} + {1'b0, b_i[bi*ARITY-1:0]}
                        + {{(bi*ARITY){1'b0}}, cin};
         always_comb begin
            a_r8_slice_entry: assert (blk_c[bi] == low_sum[bi*ARITY])
               else $error("slice entry carry wrong");
         end
      end
   endgenerate
endmodule

// File: tb/sim_cla_adder16.sv
module sim_cla_adder16;
   localparam int W = 16;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic [W-1:0] a, b, sum;
   logic         ci, co, gg, gp;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   cla_adder16 #(.WIDTH(W)) u0 (
      .a_i(a), .b_i(b), .cin(ci),
      .sum_o(sum), .cout(co), .grp_g(gg), .grp_p(gp)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, a, b, ci, got, exp);
      end
   endtask

   // drive at rising edge, sample at falling edge
   task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
      logic [W:0] full, nocin;
      @(posedge clk);
      a = av; b = bv; ci = cv;
      @(negedge clk);
      full  = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
      nocin = {1'b0, av} + {1'b0, bv};
      check("R1", {16'h0, sum}, {16'h0, full[W-1:0]});
      check("R2", {31'h0, co}, {31'h0, full[W]});
      check("R3", {31'h0, gg}, {31'h0, nocin[W]});
      check("R4", {31'h0, gp}, {31'h0, (av ^ bv) == 16'hFFFF});
      check("R5", {31'h0, gg & gp}, 32'h0);
   endtask

   // nibble pattern: 0 kill, 1 generate, 2 pass, 3 mixed
   function automatic logic [7:0] nib(input int mode);
      case (mode)
         0: return 8'h00;
         1: return 8'hFF;
         2: return 8'h5A;
         default: return 8'h31;
      endcase
   endfunction

   initial begin
      logic [W-1:0] lfsr;
      logic [W:0]   r;
      a = '0; b = '0; ci = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      // reset / idle state: zero inputs
      check("R1", {16'h0, sum}, 32'h0);
      check("R2", {31'h0, co}, 32'h0);

      // sweep every slice-pattern combination with both carry-ins
      for (int combo = 0; combo < 256; combo++) begin
         for (int c = 0; c < 2; c++) begin
            logic [W-1:0] av, bv;
            for (int s = 0; s < 4; s++) begin
               logic [7:0] n;
               n = nib((combo >> (2*s)) & 3);
               av[4*s +: 4] = n[7:4];
               bv[4*s +: 4] = n[3:0];
            end
            apply(av, bv, c[0]);
         end
      end

      // R6: all bits pass the carry
      apply(16'hA5C3, 16'h5A3C, 1'b1);
      check("R6", {15'h0, co, sum}, {15'h0, 1'b1, 16'h0000});
      apply(16'hA5C3, 16'h5A3C, 1'b0);
      check("R6", {15'h0, co, sum}, {15'h0, 1'b0, 16'hFFFF});
      check("R6", {31'h0, gp}, 32'h1);

      // R7: carry born at bit 0 ripples across every boundary
      apply(16'h0001, 16'hFFFF, 1'b0);
      check("R7", {15'h0, co, sum}, {15'h0, 1'b1, 16'h0000});
      check("R7", {31'h0, gg}, 32'h1);
      apply(16'h0001, 16'hFFFF, 1'b1);
      check("R7", {15'h0, co, sum}, {15'h0, 1'b1, 16'h0001});

      // R8: zero upper slices show the entry carry as their nibble
      apply(16'h000F, 16'h0001, 1'b0);
      check("R8", {16'h0, sum}, 32'h0010);
      apply(16'h00FF, 16'h0001, 1'b0);
      check("R8", {16'h0, sum}, 32'h0100);
      apply(16'h0FFF, 16'h0000, 1'b1);
      check("R8", {16'h0, sum}, 32'h1000);

      // pseudo-random vectors
      lfsr = 16'hACE1;
      for (int n = 0; n < 3000; n++) begin
         logic [W-1:0] av;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         av = lfsr;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         apply(av, lfsr ^ 16'h3C5A, lfsr[3]);
      end
      r = '0;
      done = 1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (150000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
         end
      join_any
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule